// File: doc/BRIEF.md
# Four-Level Radix Page Table Walker

This block turns a virtual address into a physical page by fetching one 64-bit entry from each level of a four-level radix table held in memory. A client hands it a table root address, a 48-bit virtual address and an access kind (read, write or execute). The walker fetches the top directory entry, the two middle directory entries and the final page entry in turn, computing each fetch address from the entry just returned. It stops early when an entry is invalid, when an execute access meets an entry marked no-execute, or when an unsupported encoding is seen.

The third level may end the walk itself as a large-page leaf, with its page size taken from a fragment field in the entry. The block returns the leaf entry, the aligned physical and virtual page addresses, the log2 page size and fault and error information. Its memory port offers one read at a time. A read the memory refuses is parked until the memory signals retry. Each read also carries a flag that marks it uncacheable, derived from the entry fetched before it.

Top module: `ptw_top`

## Requirements
- R1: After reset `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0. A request is taken only while `req_ready` is high. `req_ready` stays low from acceptance until the response handshake (`rsp_valid` && `rsp_ready`), and is high in the next cycle.
- R2: The first read address is ({base[47:6],6'b0} + vpn[35:27]*8) mod 2^48, where vpn = vaddr[47:12].
- R3: Each later read address is ({entry[47:6],6'b0} + index*8) mod 2^48, taken from the entry just returned. The index is vpn[26:18] after the top level, vpn[17:9] after the second level and vpn[8:0] after the third. The walk issues exactly one read per visited level.
- R4: A walk that reaches the fourth level returns that entry on `rsp_entry`, `rsp_logsize`=12 and `rsp_paddr` = entry[47:0] with bits [11:0] cleared.
- R5: A third-level entry with bit 54 set and no fault or error is the leaf. Its `rsp_logsize` = 12 + min(9, entry[11:7]), and `rsp_paddr` = entry[47:0] with bits below `rsp_logsize` cleared.
- R6: `rsp_vaddr` is the request's virtual address with bits below `rsp_logsize` cleared.
- R7: An entry with bit 0 clear ends the walk at that level. The response then has `rsp_fault`=1, `rsp_present`=0, `rsp_paddr`=0 and `rsp_logsize`=12.
- R8: An entry with bit 4 set ends the walk with `rsp_fault`=1 and `rsp_present`=1, but only if the mode is execute (2) and `nx_check_en`=1; read or write mode is unaffected. `rsp_cause` is 1 for write mode, 2 for execute mode and 0 for read mode (0) and for mode code 3.
- R9: The first read of a walk has `mem_req_uncached`=0. Every later read has `mem_req_uncached` equal to the inverse of bit 2 of the entry just returned.
- R10: After a read is refused (`mem_req_valid` high with `mem_req_accept` low), no read is offered until a cycle with `mem_retry` high. The resent read carries the same address.
- R11: While an accepted read has no response, `mem_req_valid` stays low, and `mem_retry` in that window causes no extra read.
- R12: A nonzero entry[63:59], or bit 54 set at the first or second level, ends the walk with `rsp_error`=1 and `rsp_paddr`=0.
- R13: While `rsp_valid` is high and `rsp_ready` low, all response outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_base | input | 48 | Table root address |
| req_vaddr | input | 48 | Virtual address to translate |
| req_mode | input | 2 | 0 read, 1 write, 2 execute, 3 as read |
| nx_check_en | input | 1 | Enable the no-execute check |
| mem_req_valid | output | 1 | Read offered this cycle |
| mem_req_addr | output | 48 | Byte address of the 8-byte entry |
| mem_req_uncached | output | 1 | Read marked uncacheable |
| mem_req_accept | input | 1 | Memory takes the offered read |
| mem_retry | input | 1 | Memory can now take a refused read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry value |
| rsp_valid | output | 1 | Walk result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_entry | output | 64 | Last entry fetched |
| rsp_paddr | output | 48 | Physical page address |
| rsp_vaddr | output | 48 | Page-aligned virtual address |
| rsp_logsize | output | 5 | log2 of the page size |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_present | output | 1 | Valid bit of the faulting entry |
| rsp_cause | output | 2 | 0 load, 1 store, 2 instruction |
| rsp_error | output | 1 | Unsupported entry encoding seen |

## Verification
The hardest situation to reach from the ports is a refused read followed by a retry, combined with retry pulses that arrive while an accepted read is still in flight. Both a duplicate read and a lost read would stay hidden in plain walks. The bench memory model can refuse the first offer of every read, pulse retry a few cycles later, and assert retry spuriously on every cycle of a pending response. Each offered address is compared with a queue the bench derives from its own table walk. Large-page sizing is covered by leaf entries whose fragment field lies below, at and above the cap.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_RETRY,
        ST_WAIT,
        ST_DONE
    } walk_st_e;

    localparam int unsigned TBL_ALIGN = 6;
    localparam int unsigned ENT_LOG   = 3;

    localparam int unsigned BIT_VALID = 0;
    localparam int unsigned BIT_CACHE = 2;
    localparam int unsigned BIT_NOEXE = 4;
    localparam int unsigned BIT_LEAF  = 54;
    localparam int unsigned FRAG_LO   = 7;
    localparam int unsigned FRAG_W    = 5;
    localparam int unsigned BFS_LO    = 59;
    localparam int unsigned BFS_W     = 5;

    localparam logic [1:0] MODE_WRITE = 2'd1;
    localparam logic [1:0] MODE_EXEC  = 2'd2;

    localparam logic [1:0] CAUSE_LOAD  = 2'd0;
    localparam logic [1:0] CAUSE_STORE = 2'd1;
    localparam logic [1:0] CAUSE_INSTR = 2'd2;

    localparam logic [1:0] LVL_TOP  = 2'd0;
    localparam logic [1:0] LVL_MID  = 2'd1;
    localparam logic [1:0] LVL_DIR  = 2'd2;
    localparam logic [1:0] LVL_PAGE = 2'd3;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int unsigned PA_W  = 48,
    parameter int unsigned IDX_W = 9
) (
    input  logic [PA_W-TBL_ALIGN-1:0] tbl_hi,
    input  logic [IDX_W-1:0]          idx,
    output logic [PA_W-1:0]           addr
);
    localparam int unsigned PAD_W = PA_W - IDX_W - ENT_LOG;

    logic [PA_W-1:0] tbl_base;
    logic [PA_W-1:0] slot_off;

    always_comb begin
        tbl_base = {tbl_hi, {TBL_ALIGN{1'b0}}};
        slot_off = {{PAD_W{1'b0}}, idx, {ENT_LOG{1'b0}}};
        addr     = tbl_base + slot_off;
    end
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned FRAG_MAX   = 9,
    parameter int unsigned LS_W       = 5
) (
    input  logic              e_valid,
    input  logic              e_noexe,
    input  logic              e_leaf,
    input  logic [FRAG_W-1:0] e_frag,
    input  logic [BFS_W-1:0]  e_bfs,
    input  logic [1:0]        level,
    input  logic [1:0]        mode,
    input  logic              nx_en,
    output logic              walk_end,
    output logic              fault,
    output logic              present,
    output logic              err,
    output logic [1:0]        cause,
    output logic [LS_W-1:0]   logsize
);
    localparam logic [FRAG_W-1:0] FRAG_CAP = FRAG_W'(FRAG_MAX);

    logic              is_leaf;
    logic [FRAG_W-1:0] frag_used;

    always_comb begin
        err      = (|e_bfs) | (e_leaf & ((level == LVL_TOP) | (level == LVL_MID)));
        fault    = ~e_valid | (e_noexe & (mode == MODE_EXEC) & nx_en);
        present  = e_valid;
        is_leaf  = (level == LVL_PAGE) | ((level == LVL_DIR) & e_leaf);
        walk_end = is_leaf | err | fault;

        case (mode)
            MODE_WRITE: cause = CAUSE_STORE;
            MODE_EXEC:  cause = CAUSE_INSTR;
            default:    cause = CAUSE_LOAD;
        endcase

        frag_used = (e_frag > FRAG_CAP) ? FRAG_CAP : e_frag;
        if ((level == LVL_DIR) && e_leaf && !err && !fault)
            logsize = LS_W'(PAGE_SHIFT) + LS_W'(frag_used);
        else
            logsize = LS_W'(PAGE_SHIFT);
    end
endmodule

// File: rtl/ptw_leaf_fmt.sv
module ptw_leaf_fmt #(
    parameter int unsigned PA_W       = 48,
    parameter int unsigned VPN_W      = 36,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned LS_W       = 5
) (
    input  logic [PA_W-1:0]             entry_pa,
    input  logic [VPN_W-1:0]            vpn,
    input  logic [LS_W-1:0]             logsize,
    input  logic                        squash,
    output logic [PA_W-1:0]             paddr,
    output logic [VPN_W+PAGE_SHIFT-1:0] vaddr
);
    localparam int unsigned VA_W = VPN_W + PAGE_SHIFT;

    logic [PA_W-1:0] pa_keep;
    logic [VA_W-1:0] va_keep;

    always_comb begin
        pa_keep = {PA_W{1'b1}} << logsize;
        va_keep = {VA_W{1'b1}} << logsize;
        paddr   = squash ? '0 : (entry_pa & pa_keep);
        vaddr   = {vpn, {PAGE_SHIFT{1'b0}}} & va_keep;
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int unsigned PA_W       = 48,
    parameter int unsigned IDX_W      = 9,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned FRAG_MAX   = 9,
    parameter int unsigned VA_W       = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [PA_W-1:0] req_base,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_mode,
    input  logic            nx_check_en,
    output logic            mem_req_valid,
    output logic [PA_W-1:0] mem_req_addr,
    output logic            mem_req_uncached,
    input  logic            mem_req_accept,
    input  logic            mem_retry,
    input  logic            mem_rsp_valid,
    input  logic [63:0]     mem_rsp_data,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [63:0]     rsp_entry,
    output logic [PA_W-1:0] rsp_paddr,
    output logic [VA_W-1:0] rsp_vaddr,
    output logic [4:0]      rsp_logsize,
    output logic            rsp_fault,
    output logic            rsp_present,
    output logic [1:0]      rsp_cause,
    output logic            rsp_error
);
    localparam int unsigned LEVELS = 4;
    localparam int unsigned VPN_W  = LEVELS * IDX_W;
    localparam int unsigned LS_W   = $clog2(PAGE_SHIFT + FRAG_MAX + 1);

    typedef struct packed {
        walk_st_e         st;
        logic [1:0]       lvl;
        logic [PA_W-1:0]  addr;
        logic             unc;
        logic [VPN_W-1:0] vpn;
        logic [1:0]       mode;
        logic             nx;
        logic [63:0]      entry;
        logic [PA_W-1:0]  paddr;
        logic [VA_W-1:0]  vaddr;
        logic [LS_W-1:0]  ls;
        logic             fault;
        logic             present;
        logic             err;
        logic [1:0]       cause;
    } walk_t;

    walk_t q, d;

    logic [IDX_W-1:0] idx_slice [LEVELS];
    logic [IDX_W-1:0] first_idx;
    logic [IDX_W-1:0] next_idx;
    logic [PA_W-1:0]  first_addr;
    logic [PA_W-1:0]  next_addr;

    logic             chk_end;
    logic             chk_fault;
    logic             chk_present;
    logic             chk_err;
    logic [1:0]       chk_cause;
    logic [LS_W-1:0]  chk_ls;
    logic [PA_W-1:0]  fmt_paddr;
    logic [VA_W-1:0]  fmt_vaddr;

    logic unused_low_bits;
    assign unused_low_bits = ^{req_base[TBL_ALIGN-1:0], req_vaddr[PAGE_SHIFT-1:0]};

    for (genvar k = 0; k < LEVELS; k++) begin : g_slice
        assign idx_slice[k] = q.vpn[VPN_W-1-k*IDX_W -: IDX_W];
    end

    assign first_idx = req_vaddr[VA_W-1 -: IDX_W];
    assign next_idx  = idx_slice[2'(q.lvl + 2'd1)];

    ptw_addr_gen #(.PA_W(PA_W), .IDX_W(IDX_W)) u_first_addr (
        .tbl_hi (req_base[PA_W-1:TBL_ALIGN]),
        .idx    (first_idx),
        .addr   (first_addr)
    );

    ptw_addr_gen #(.PA_W(PA_W), .IDX_W(IDX_W)) u_next_addr (
        .tbl_hi (mem_rsp_data[PA_W-1:TBL_ALIGN]),
        .idx    (next_idx),
        .addr   (next_addr)
    );

    ptw_entry_check #(
        .PAGE_SHIFT (PAGE_SHIFT),
        .FRAG_MAX   (FRAG_MAX),
        .LS_W       (LS_W)
    ) u_check (
        .e_valid  (mem_rsp_data[BIT_VALID]),
        .e_noexe  (mem_rsp_data[BIT_NOEXE]),
        .e_leaf   (mem_rsp_data[BIT_LEAF]),
        .e_frag   (mem_rsp_data[FRAG_LO +: FRAG_W]),
        .e_bfs    (mem_rsp_data[BFS_LO +: BFS_W]),
        .level    (q.lvl),
        .mode     (q.mode),
        .nx_en    (q.nx),
        .walk_end (chk_end),
        .fault    (chk_fault),
        .present  (chk_present),
        .err      (chk_err),
        .cause    (chk_cause),
        .logsize  (chk_ls)
    );

    ptw_leaf_fmt #(
        .PA_W       (PA_W),
        .VPN_W      (VPN_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .LS_W       (LS_W)
    ) u_fmt (
        .entry_pa (mem_rsp_data[PA_W-1:0]),
        .vpn      (q.vpn),
        .logsize  (chk_ls),
        .squash   (chk_fault | chk_err),
        .paddr    (fmt_paddr),
        .vaddr    (fmt_vaddr)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_SEND;
                    d.lvl  = LVL_TOP;
                    d.addr = first_addr;
                    d.unc  = 1'b0;
                    d.vpn  = req_vaddr[VA_W-1:PAGE_SHIFT];
                    d.mode = req_mode;
                    d.nx   = nx_check_en;
                end
            end
            ST_SEND: begin
                d.st = mem_req_accept ? ST_WAIT : ST_RETRY;
            end
            ST_RETRY: begin
                if (mem_retry)
                    d.st = ST_SEND;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (chk_end) begin
                        d.st      = ST_DONE;
                        d.entry   = mem_rsp_data;
                        d.paddr   = fmt_paddr;
                        d.vaddr   = fmt_vaddr;
                        d.ls      = chk_ls;
                        d.fault   = chk_fault;
                        d.present = chk_present;
                        d.err     = chk_err;
                        d.cause   = chk_cause;
                    end else begin
                        d.st   = ST_SEND;
                        d.addr = next_addr;
                        d.unc  = ~mem_rsp_data[BIT_CACHE];
                        d.lvl  = q.lvl + 2'd1;
                    end
                end
            end
            ST_DONE: begin
                if (rsp_ready)
                    d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign req_ready        = (q.st == ST_IDLE);
    assign mem_req_valid    = (q.st == ST_SEND);
    assign mem_req_addr     = q.addr;
    assign mem_req_uncached = q.unc;
    assign rsp_valid        = (q.st == ST_DONE);
    assign rsp_entry        = q.entry;
    assign rsp_paddr        = q.paddr;
    assign rsp_vaddr        = q.vaddr;
    assign rsp_logsize      = 5'(q.ls);
    assign rsp_fault        = q.fault;
    assign rsp_present      = q.present;
    assign rsp_cause        = q.cause;
    assign rsp_error        = q.err;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int unsigned PA_W       = 48,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned FRAG_MAX   = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [63:0]     rsp_entry,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [4:0]      rsp_logsize,
    input logic            rsp_fault,
    input logic            rsp_error,
    input logic            mem_req_valid,
    input logic            mem_req_accept,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            mem_retry
);
    logic            inflight_q;
    logic            parked_q;
    logic            resend_q;
    logic [PA_W-1:0] parked_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight_q    <= 1'b0;
            parked_q      <= 1'b0;
            resend_q      <= 1'b0;
            parked_addr_q <= '0;
        end else begin
            if (mem_req_valid && mem_req_accept)
                inflight_q <= 1'b1;
            else if (mem_rsp_valid)
                inflight_q <= 1'b0;
            parked_q <= (mem_req_valid && !mem_req_accept) || (parked_q && !mem_retry);
            if (mem_req_valid && !mem_req_accept) begin
                resend_q      <= 1'b1;
                parked_addr_q <= mem_req_addr;
            end else if (mem_req_valid) begin
                resend_q <= 1'b0;
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    assert_back_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> req_ready);

    assert_entry_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    assert_logsize_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_logsize >= 5'(PAGE_SHIFT)) && (rsp_logsize <= 5'(PAGE_SHIFT + FRAG_MAX))));

    assert_fault_zero_paddr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault || rsp_error)) |-> (rsp_paddr == '0));

    assert_wait_for_retry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        parked_q |-> !mem_req_valid);

    assert_resend_same_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && resend_q) |-> (mem_req_addr == parked_addr_q));

    assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q |-> !mem_req_valid);

    assert_rsp_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_entry)
                                       && $stable(rsp_logsize)));
endmodule

bind ptw_top ptw_checker #(
    .PA_W       (PA_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .FRAG_MAX   (FRAG_MAX)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_entry      (rsp_entry),
    .rsp_paddr      (rsp_paddr),
    .rsp_logsize    (rsp_logsize),
    .rsp_fault      (rsp_fault),
    .rsp_error      (rsp_error),
    .mem_req_valid  (mem_req_valid),
    .mem_req_accept (mem_req_accept),
    .mem_req_addr   (mem_req_addr),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_retry      (mem_retry)
);

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    localparam logic [63:0] F_V  = 64'h1;
    localparam logic [63:0] F_C  = 64'h4;
    localparam logic [63:0] F_X  = 64'h10;
    localparam logic [63:0] F_P  = 64'h1 << 54;
    localparam logic [63:0] F_BF = 64'h1 << 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_base = '0;
    logic [47:0] req_vaddr = '0;
    logic [1:0]  req_mode = '0;
    logic        nx_check_en = 1'b0;
    logic        mem_req_valid;
    logic [47:0] mem_req_addr;
    logic        mem_req_uncached;
    logic        mem_req_accept;
    logic        mem_retry;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_entry;
    logic [47:0] rsp_paddr;
    logic [47:0] rsp_vaddr;
    logic [4:0]  rsp_logsize;
    logic        rsp_fault;
    logic        rsp_present;
    logic [1:0]  rsp_cause;
    logic        rsp_error;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base),
        .req_vaddr(req_vaddr), .req_mode(req_mode), .nx_check_en(nx_check_en),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_uncached(mem_req_uncached), .mem_req_accept(mem_req_accept),
        .mem_retry(mem_retry), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_entry(rsp_entry),
        .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr), .rsp_logsize(rsp_logsize),
        .rsp_fault(rsp_fault), .rsp_present(rsp_present), .rsp_cause(rsp_cause),
        .rsp_error(rsp_error)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [63:0] mem [logic [47:0]];
    logic [47:0] exp_addr_q [$];
    bit          exp_unc_q [$];

    logic [63:0] exp_entry;
    logic [47:0] exp_paddr, exp_vaddr;
    int          exp_ls;
    bit          exp_fault, exp_present, exp_err;
    int          exp_cause;

    bit refuse_on = 0, spur_on = 0;
    bit outstanding = 0, pend_retry = 0, refused_this = 0;
    int lat = 0, rcnt = 0, rd_idx = 0;
    logic [47:0] acc_addr = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [47:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    task automatic chain(input logic [47:0] root, input logic [47:0] va,
                         input logic [63:0] f2, input logic [63:0] f1,
                         input logic [63:0] f0, input logic [63:0] fp,
                         input logic [47:0] page);
        logic [35:0] vpn;
        logic [47:0] t1, t2, t3;
        vpn = va[47:12];
        t1 = 48'h0000_0100_0000;
        t2 = 48'h0000_0200_0000;
        t3 = 48'h0000_0300_0000;
        mem.delete();
        mem[root + 48'(vpn[35:27]) * 8] = {16'h0, t1} | f2;
        mem[t1 + 48'(vpn[26:18]) * 8]   = {16'h0, t2} | f1;
        mem[t2 + 48'(vpn[17:9]) * 8]    = {16'h0, t3} | f0;
        mem[t3 + 48'(vpn[8:0]) * 8]     = {16'h0, page} | fp;
    endtask

    task automatic model_walk(input logic [47:0] base, input logic [47:0] va,
                              input logic [1:0] mode, input bit nx);
        logic [35:0] vpn;
        logic [47:0] a;
        logic [63:0] e;
        logic [8:0]  idx;
        bit unc, v, x, p, err, flt, leaf;
        int ls;
        vpn = va[47:12];
        unc = 0;
        exp_addr_q.delete();
        exp_unc_q.delete();
        a = {base[47:6], 6'b0} + 48'(vpn[35:27]) * 8;
        for (int lvl = 0; lvl < 4; lvl++) begin
            exp_addr_q.push_back(a);
            exp_unc_q.push_back(unc);
            e = rd(a);
            v = e[0]; x = e[4]; p = e[54];
            err  = (e[63:59] != 0) || (p && lvl < 2);
            flt  = !v || (x && mode == 2'd2 && nx);
            leaf = (lvl == 3) || (lvl == 2 && p);
            if (err || flt || leaf) begin
                ls = 12;
                if (!err && !flt && lvl == 2)
                    ls = 12 + ((int'(e[11:7]) > 9) ? 9 : int'(e[11:7]));
                exp_entry   = e;
                exp_ls      = ls;
                exp_fault   = flt;
                exp_err     = err;
                exp_present = v;
                exp_cause   = (mode == 2'd1) ? 1 : ((mode == 2'd2) ? 2 : 0);
                exp_paddr   = (err || flt) ? 48'h0 : ((e[47:0] >> ls) << ls);
                exp_vaddr   = ({vpn, 12'h0} >> ls) << ls;
                break;
            end
            idx = (lvl == 0) ? vpn[26:18] : ((lvl == 1) ? vpn[17:9] : vpn[8:0]);
            a   = {e[47:6], 6'b0} + 48'(idx) * 8;
            unc = !e[2];
        end
    endtask

    // memory model and per-cycle protocol comparison
    initial begin
        bit was_out, was_pend;
        string tag;
        mem_req_accept = 0; mem_rsp_valid = 0; mem_retry = 0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_req_accept = 0; mem_rsp_valid = 0; mem_retry = 0;
            if (rst_n) begin
                was_out  = outstanding;
                was_pend = pend_retry;
                if (outstanding) begin
                    if (lat == 0) begin
                        mem_rsp_valid = 1;
                        mem_rsp_data  = rd(acc_addr);
                        outstanding   = 0;
                    end else begin
                        lat--;
                        if (spur_on) mem_retry = 1;
                    end
                end else if (pend_retry) begin
                    if (rcnt == 0) begin
                        mem_retry  = 1;
                        pend_retry = 0;
                    end else rcnt--;
                end
                if (mem_req_valid) begin
                    chk(!was_out, "R11", "read offered while one outstanding", 64'(mem_req_valid), 64'h0);
                    chk(!was_pend, "R10", "read offered before retry", 64'(mem_req_valid), 64'h0);
                    if (exp_addr_q.size() == 0) begin
                        chk(0, "R3", "extra read", {16'h0, mem_req_addr}, 64'h0);
                    end else begin
                        tag = refused_this ? "R10" : ((rd_idx == 0) ? "R2" : "R3");
                        chk(mem_req_addr == exp_addr_q[0], tag, "read address",
                            {16'h0, mem_req_addr}, {16'h0, exp_addr_q[0]});
                        chk(mem_req_uncached == exp_unc_q[0], "R9", "uncached flag",
                            64'(mem_req_uncached), 64'(exp_unc_q[0]));
                    end
                    if (refuse_on && !refused_this) begin
                        refused_this = 1;
                        pend_retry   = 1;
                        rcnt         = 3;
                    end else begin
                        mem_req_accept = 1;
                        if (exp_addr_q.size() != 0) begin
                            void'(exp_addr_q.pop_front());
                            void'(exp_unc_q.pop_front());
                        end
                        outstanding  = 1;
                        lat          = 2;
                        acc_addr     = mem_req_addr;
                        refused_this = 0;
                        rd_idx++;
                    end
                end
            end
        end
    end

    task automatic run_walk(input logic [47:0] base, input logic [47:0] va,
                            input logic [1:0] mode, input bit nx, input int hold);
        int cnt;
        logic [63:0] held_entry;
        logic [47:0] held_paddr;
        logic [4:0]  held_ls;
        model_walk(base, va, mode, nx);
        rd_idx = 0;
        chk(req_ready === 1'b1, "R1", "ready before request", 64'(req_ready), 64'h1);
        req_valid = 1; req_base = base; req_vaddr = va; req_mode = mode; nx_check_en = nx;
        @(negedge clk);
        req_valid = 0;
        cnt = 0;
        while (!rsp_valid && cnt < 2000) begin
            chk(req_ready === 1'b0, "R1", "ready low during walk", 64'(req_ready), 64'h0);
            @(negedge clk);
            cnt++;
        end
        chk(rsp_valid === 1'b1, "R1", "response arrives", 64'(rsp_valid), 64'h1);
        chk(rsp_entry === exp_entry, "R4", "entry", rsp_entry, exp_entry);
        chk(rsp_paddr === exp_paddr, "R4", "paddr", {16'h0, rsp_paddr}, {16'h0, exp_paddr});
        chk(rsp_logsize === 5'(exp_ls), "R5", "logsize", 64'(rsp_logsize), 64'(exp_ls));
        chk(rsp_vaddr === exp_vaddr, "R6", "vaddr", {16'h0, rsp_vaddr}, {16'h0, exp_vaddr});
        chk(rsp_fault === exp_fault, "R7", "fault", 64'(rsp_fault), 64'(exp_fault));
        chk(rsp_present === exp_present, "R7", "present", 64'(rsp_present), 64'(exp_present));
        chk(rsp_cause === 2'(exp_cause), "R8", "cause", 64'(rsp_cause), 64'(exp_cause));
        chk(rsp_error === exp_err, "R12", "error", 64'(rsp_error), 64'(exp_err));
        chk(exp_addr_q.size() == 0, "R3", "reads left unissued", 64'(exp_addr_q.size()), 64'h0);
        held_entry = rsp_entry; held_paddr = rsp_paddr; held_ls = rsp_logsize;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(rsp_valid === 1'b1 && rsp_entry === held_entry && rsp_paddr === held_paddr
                && rsp_logsize === held_ls, "R13", "response held",
                {16'h0, rsp_paddr}, {16'h0, held_paddr});
        end
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk(rsp_valid === 1'b0, "R1", "valid drops after handshake", 64'(rsp_valid), 64'h0);
        chk(req_ready === 1'b1, "R1", "idle after handshake", 64'(req_ready), 64'h1);
    endtask

    initial begin
        logic [47:0] root, va1, va2, pg;
        root = 48'h0000_0040_0000;
        va1  = 48'h1234_5678_9ABC;
        va2  = 48'hFEDC_BA98_7654;
        pg   = 48'h0000_7777_7000;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R1",
            "outputs in reset", {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R1",
            "state after reset", {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);

        // R2 R3 R4 R9: full walk, low root bits ignored, mid level not cacheable
        chain(root, va1, F_V|F_C, F_V, F_V|F_C, F_V|F_C, pg);
        run_walk(root | 48'h25, va1, 2'd0, 1'b1, 0);
        // R5: large-page leaf at the third level, fragment below, above and at zero
        chain(root, va1, F_V|F_C, F_V|F_C, F_V|F_P|(64'd5 << 7), F_V, pg);
        run_walk(root, va1, 2'd0, 1'b1, 0);
        chain(root, va2, F_V, F_V, F_V|F_P|(64'd20 << 7), F_V, pg);
        run_walk(root, va2, 2'd1, 1'b1, 0);
        chain(root, va2, F_V|F_C, F_V, F_V|F_P, F_V, pg);
        run_walk(root, va2, 2'd0, 1'b1, 0);
        // R7: invalid entries at different levels and modes
        chain(root, va1, F_V|F_C, F_C, F_V, F_V, pg);
        run_walk(root, va1, 2'd0, 1'b1, 0);
        chain(root, va2, F_V, F_V, F_V, 64'h0, pg);
        run_walk(root, va2, 2'd1, 1'b1, 0);
        run_walk(root, va2, 2'd3, 1'b1, 0);
        // R8: no-execute bit
        chain(root, va1, F_V|F_C, F_V|F_C, F_V|F_C, F_V|F_X, pg);
        run_walk(root, va1, 2'd2, 1'b1, 0);
        run_walk(root, va1, 2'd2, 1'b0, 0);
        run_walk(root, va1, 2'd0, 1'b1, 0);
        // R12: unsupported encodings
        chain(root, va2, F_V|F_P, F_V, F_V, F_V, pg);
        run_walk(root, va2, 2'd0, 1'b1, 0);
        chain(root, va2, F_V, F_V|F_P, F_V, F_V, pg);
        run_walk(root, va2, 2'd0, 1'b1, 0);
        chain(root, va2, F_V, F_V, F_V|F_BF, F_V, pg);
        run_walk(root, va2, 2'd0, 1'b1, 0);
        // R10 R11: refuse every first offer, spurious retry while a read is in flight
        refuse_on = 1; spur_on = 1;
        chain(root, va1, F_V|F_C, F_V, F_V|F_C, F_V|F_C, pg);
        run_walk(root, va1, 2'd0, 1'b1, 0);
        refuse_on = 0; spur_on = 0;
        // R13: client stalls the response
        chain(root, va2, F_V|F_C, F_V|F_C, F_V|F_P|(64'd9 << 7), F_V, pg);
        run_walk(root, va2, 2'd0, 1'b1, 3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule